// File: doc/BRIEF.md
# Iterative Learning Peak-Current Reference Generator

This block sets the peak-current threshold for each switching cycle of a two-phase interleaved power-factor stage. The switching cycles of one grid period are numbered from zero. For every position the block keeps one learned correction word. When a switching cycle is announced, the block takes two signed fixed-point samples: the wanted input current and the predicted average current. It forms their difference and updates the stored correction for the current position. The update is a forgetting-factor-weighted copy of the old correction plus a gain-weighted copy of the error. The block then presents the threshold as the phase count times the wanted current plus the new correction. This threshold goes to the comparator DAC on the next clock edge.

The learning runs across grid periods. Position n of one period corrects position n of the next period, so errors that repeat every period are removed. A forgetting factor below one slowly bleeds off error that does not repeat. A factor of exactly one gives plain accumulation, which is useful for the first few periods. A grid-period start strobe realigns the position counter whenever the period is shorter than the memory.

Top module: `ilc_peak_ref`

## Requirements
- R1: After reset `peakOut` is 0, `peakValid` is 0, and every stored correction is zero. With zero gain and a forgetting factor of 1.0, the first period's output is therefore exactly `PHASES*iRef`.
- R2: The tracking error is `iRef - iAvg`. Both inputs are signed Q8.8 amperes (LSB 1/256 A). The error is formed at full width without wrap.
- R3: The new correction at index n is `floor(forgetFac*u/65536) + floor(learnGain*e/65536)`. Here u is the stored Q8.8 correction at n and e is the error. `learnGain` is unsigned Q0.16 and `forgetFac` is unsigned Q1.16 (0x10000 = 1.0). The result replaces the stored value at n.
- R4: The new correction is saturated to the range `[-corrLimit, +corrLimit]` before it is stored or used. `corrLimit` is unsigned Q8.8.
- R5: The peak output is `PHASES*iRef + newCorrection` in units of 1/256 A. It is clamped to 0 when negative and to `2^DAC_W-1` when above full scale.
- R6: A `cycleStb` sampled high at a rising edge updates `peakOut` and pulses `peakValid` high for one cycle at that edge. In cycles without `cycleStb`, `peakValid` is low and `peakOut` holds.
- R7: Each `cycleStb` advances the index by one. The index returns to 0 after index `DEPTH-1`.
- R8: `periodStb` forces the index to 0. When it coincides with `cycleStb`, that sample uses index 0 and the next sample uses index 1. Entries not reached in a period cut short keep their stored values.
- R9: With `forgetFac` = 0x10000 and zero gain, a stored correction passes unchanged from period to period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycleStb | input | 1 | One switching cycle's samples are valid |
| periodStb | input | 1 | Grid period start; index returns to 0 |
| iRef | input | DATA_W | Wanted current, signed Q8.8 |
| iAvg | input | DATA_W | Predicted average current, signed Q8.8 |
| learnGain | input | COEF_W | Learning gain, unsigned Q0.16 |
| forgetFac | input | COEF_W+1 | Forgetting factor, unsigned Q1.16 |
| corrLimit | input | DATA_W-1 | Correction magnitude limit, unsigned Q8.8 |
| peakOut | output | DAC_W | Peak threshold code, 1/256 A per LSB |
| peakValid | output | 1 | One-cycle pulse with each new threshold |

## Verification
Every result is due at the first rising edge that samples `cycleStb` high. The new `peakOut`, the `peakValid` pulse and the memory write all happen at that edge, with no further pipeline stage. A correction written there first shows up in the output one grid period later, when the same index comes round again. The bench drives strobes and samples on falling edges and reads the output at the falling edge just after the capturing edge. It leaves an idle cycle between samples, so holding and the low `peakValid` can be checked. A reference model of the memory and index is updated in step, so the bench sees each stored correction through later outputs, including entries skipped by an early `periodStb`.

// File: rtl/ilc_pkg.sv
package ilc_pkg;
  typedef struct packed {
    logic sample;
    logic restart;
  } ilcCtl_t;
endpackage

// File: rtl/ilc_ctrl.sv
module ilc_ctrl
  import ilc_pkg::*;
#(
  parameter int DEPTH = 2000,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cycleStb,
  input  logic             periodStb,
  output ilcCtl_t          ctl,
  output logic [IDX_W-1:0] idxQ
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] baseIdx;

  // a period start overrides the running position
  assign baseIdx     = periodStb ? '0 : idxQ;
  assign ctl.sample  = cycleStb;
  assign ctl.restart = periodStb;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ <= '0;
    end else if (cycleStb) begin
      idxQ <= (baseIdx == LAST) ? '0 : baseIdx + IDX_W'(1);
    end else if (periodStb) begin
      idxQ <= '0;
    end
  end
endmodule

// File: rtl/ilc_datapath.sv
module ilc_datapath
  import ilc_pkg::*;
#(
  parameter int DEPTH   = 2000,
  parameter int DATA_W  = 16,
  parameter int COEF_W  = 16,
  parameter int DAC_W   = 12,
  parameter int PHASES  = 2,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int PW     = DATA_W + COEF_W + 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ilcCtl_t                  ctl,
  input  logic [IDX_W-1:0]         idxQ,
  input  logic signed [DATA_W-1:0] iRef,
  input  logic signed [DATA_W-1:0] iAvg,
  input  logic [COEF_W-1:0]        learnGain,
  input  logic [COEF_W:0]          forgetFac,
  input  logic [DATA_W-2:0]        corrLimit,
  output logic [DAC_W-1:0]         peakOut,
  output logic                     peakValid
);
  localparam logic signed [PW-1:0] DAC_MAX = PW'((1 << DAC_W) - 1);

  logic signed [DATA_W-1:0] corrMem [DEPTH];

  logic [IDX_W-1:0]     rdIdx;
  logic signed [PW-1:0] errW, uW, gW, fW, kW;
  logic signed [PW-1:0] fProd, gProd, sumW, limW, satW, peakW, peakSat;

  assign rdIdx = ctl.restart ? '0 : idxQ;

  always_comb begin
    errW  = PW'(iRef) - PW'(iAvg);
    uW    = PW'(corrMem[rdIdx]);
    gW    = PW'($signed({1'b0, learnGain}));
    fW    = PW'($signed({1'b0, forgetFac}));
    kW    = PW'(PHASES);
    fProd = fW * uW;
    gProd = gW * errW;
    sumW  = (fProd >>> COEF_W) + (gProd >>> COEF_W);
    limW  = PW'($signed({1'b0, corrLimit}));
    if (sumW > limW)       satW = limW;
    else if (sumW < -limW) satW = -limW;
    else                   satW = sumW;
    peakW = kW * PW'(iRef) + satW;
    if (peakW < 0)            peakSat = '0;
    else if (peakW > DAC_MAX) peakSat = DAC_MAX;
    else                      peakSat = peakW;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) corrMem[i] <= '0;
      peakOut   <= '0;
      peakValid <= 1'b0;
    end else begin
      peakValid <= ctl.sample;
      if (ctl.sample) begin
        corrMem[rdIdx] <= satW[DATA_W-1:0];
        peakOut        <= peakSat[DAC_W-1:0];
      end
    end
  end
endmodule

// File: rtl/ilc_peak_ref.sv
module ilc_peak_ref
  import ilc_pkg::*;
#(
  parameter int DEPTH   = 2000,
  parameter int DATA_W  = 16,
  parameter int COEF_W  = 16,
  parameter int DAC_W   = 12,
  parameter int PHASES  = 2,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cycleStb,
  input  logic                     periodStb,
  input  logic signed [DATA_W-1:0] iRef,
  input  logic signed [DATA_W-1:0] iAvg,
  input  logic [COEF_W-1:0]        learnGain,
  input  logic [COEF_W:0]          forgetFac,
  input  logic [DATA_W-2:0]        corrLimit,
  output logic [DAC_W-1:0]         peakOut,
  output logic                     peakValid
);
  ilcCtl_t          ctl;
  logic [IDX_W-1:0] idxQ;

  ilc_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .cycleStb(cycleStb), .periodStb(periodStb),
    .ctl(ctl), .idxQ(idxQ)
  );

  ilc_datapath #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .COEF_W(COEF_W),
    .DAC_W(DAC_W), .PHASES(PHASES)
  ) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .idxQ(idxQ),
    .iRef(iRef), .iAvg(iAvg), .learnGain(learnGain),
    .forgetFac(forgetFac), .corrLimit(corrLimit),
    .peakOut(peakOut), .peakValid(peakValid)
  );
endmodule

// File: rtl/ilc_peak_ref_chk.sv
module ilc_peak_ref_chk #(
  parameter int DEPTH  = 2000,
  parameter int DATA_W = 16,
  parameter int DAC_W  = 12,
  parameter int PHASES = 2,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     cycleStb,
  input logic                     periodStb,
  input logic signed [DATA_W-1:0] iRef,
  input logic [DATA_W-2:0]        corrLimit,
  input logic [DAC_W-1:0]         peakOut,
  input logic                     peakValid,
  input logic [IDX_W-1:0]         idxQ
);
  localparam int DAC_MAX = (1 << DAC_W) - 1;

  int kRef, loB, hiB;
  assign kRef = PHASES * int'(iRef);
  assign loB  = kRef - int'(corrLimit);
  assign hiB  = kRef + int'(corrLimit);

  AST_STROBE_VALID: assert property (@(posedge clk) disable iff (!rstN)
    cycleStb |=> peakValid); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cycleStb |=> (!peakValid && $stable(peakOut))); // R6
  AST_PEAK_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (cycleStb && loB >= 0 && hiB <= DAC_MAX) |=>
      (int'(peakOut) >= $past(loB) && int'(peakOut) <= $past(hiB))); // R4
  AST_FLOOR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (cycleStb && hiB < 0) |=> (peakOut == '0)); // R5
  AST_IDX_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (periodStb && !cycleStb) |=> (idxQ == '0)); // R8
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    int'(idxQ) < DEPTH); // R7
endmodule

bind ilc_peak_ref ilc_peak_ref_chk #(
  .DEPTH(DEPTH), .DATA_W(DATA_W), .DAC_W(DAC_W), .PHASES(PHASES)
) i_chk (
  .clk(clk), .rstN(rstN), .cycleStb(cycleStb), .periodStb(periodStb),
  .iRef(iRef), .corrLimit(corrLimit), .peakOut(peakOut),
  .peakValid(peakValid), .idxQ(idxQ)
);

// File: tb/test_ilc_peak_ref.sv
`timescale 1ns/1ps
module test_ilc_peak_ref;
  localparam int DEPTH = 8;
  localparam int DAC_W = 12;
  localparam int K     = 2;
  localparam int DMAX  = (1 << DAC_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cycleStb = 1'b0, periodStb = 1'b0;
  logic signed [15:0] iRef = '0, iAvg = '0;
  logic [15:0] learnGain = '0;
  logic [16:0] forgetFac = 17'h10000;
  logic [14:0] corrLimit = 15'h7FFF;
  logic [DAC_W-1:0] peakOut;
  logic peakValid;

  int checks = 0, errors = 0;
  longint mem [DEPTH];
  int mIdx = 0;

  always #2.5 clk = ~clk;

  ilc_peak_ref #(.DEPTH(DEPTH), .DAC_W(DAC_W), .PHASES(K)) i_ilc_peak_ref (
    .clk(clk), .rstN(rstN), .cycleStb(cycleStb), .periodStb(periodStb),
    .iRef(iRef), .iAvg(iAvg), .learnGain(learnGain), .forgetFac(forgetFac),
    .corrLimit(corrLimit), .peakOut(peakOut), .peakValid(peakValid)
  );

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runCycle(int r, int a, bit rst, string tag);
    longint e, s, lim, p;
    int eff;
    @(negedge clk);
    iRef = 16'(r); iAvg = 16'(a); cycleStb = 1'b1; periodStb = rst;
    eff = rst ? 0 : mIdx;
    e = longint'(r) - longint'(a);
    s = ((longint'(forgetFac) * mem[eff]) >>> 16) + ((longint'(learnGain) * e) >>> 16);
    lim = longint'(corrLimit);
    if (s > lim) s = lim;
    if (s < -lim) s = -lim;
    mem[eff] = s;
    mIdx = (eff == DEPTH - 1) ? 0 : eff + 1;
    p = K * longint'(r) + s;
    if (p < 0) p = 0;
    if (p > DMAX) p = DMAX;
    @(negedge clk);
    cycleStb = 1'b0; periodStb = 1'b0;
    check({tag, " R6 valid"}, longint'(peakValid), 1);
    check(tag, longint'(peakOut), p);
  endtask

  task automatic restartOnly();
    @(negedge clk);
    periodStb = 1'b1;
    @(negedge clk);
    periodStb = 1'b0;
    mIdx = 0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL R6 watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DAC_W-1:0] held;
    for (int i = 0; i < DEPTH; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    check("R1 reset peakOut", longint'(peakOut), 0);
    check("R1 reset peakValid", longint'(peakValid), 0);
    rstN = 1'b1;

    // R1/R9: zero gain, unity forgetting: output is K*iRef exactly
    learnGain = 16'h0000; forgetFac = 17'h10000;
    for (int n = 0; n < DEPTH; n++) runCycle(100 + 37 * n, 50, 1'b0, "R1 zero memory");

    // R2/R3/R7: learning across three periods, mixed-sign errors
    learnGain = 16'h4000;
    for (int p = 0; p < 3; p++)
      for (int n = 0; n < DEPTH; n++)
        runCycle(256 + 20 * n, 256 + 20 * n - ((n % 3) - 1) * (90 + 13 * n), 1'b0, "R3 learn");

    // R3: forgetting factor below one, small gain
    learnGain = 16'h028F; forgetFac = 17'h0FD71;
    for (int p = 0; p < 2; p++)
      for (int n = 0; n < DEPTH; n++)
        runCycle(300 - 40 * n, 500 + 11 * n, 1'b0, "R3 forget");

    // R9: unity forgetting, zero gain carries corrections unchanged
    learnGain = 16'h0000; forgetFac = 17'h10000;
    for (int n = 0; n < DEPTH; n++) runCycle(400, 0, 1'b0, "R9 hold");

    // R4: saturation both ways with a small limit
    corrLimit = 15'h0040; learnGain = 16'h8000;
    for (int n = 0; n < DEPTH; n++)
      runCycle(512, (n % 2 == 0) ? 512 - 2000 : 512 + 2000, 1'b0, "R4 saturate");

    // R5: clamp low and high
    corrLimit = 15'h0100; learnGain = 16'h1000;
    runCycle(-300, -250, 1'b0, "R5 clamp low");
    runCycle(16'h0900, 16'h0800, 1'b0, "R5 clamp high");
    runCycle(2047, 2047, 1'b0, "R5 near full");

    // R6: idle cycles keep output and drop valid
    @(negedge clk);
    held = peakOut;
    repeat (2) @(negedge clk);
    check("R6 idle valid", longint'(peakValid), 0);
    check("R6 idle hold", longint'(peakOut), longint'(held));

    // R8: short period with coincident start, then standalone start
    corrLimit = 15'h7FFF; learnGain = 16'h2000; forgetFac = 17'h10000;
    runCycle(200, 100, 1'b1, "R8 coincident start");
    runCycle(210, 90, 1'b0, "R8 second index");
    runCycle(220, 80, 1'b0, "R8 third index");
    restartOnly();
    // read back all entries: 0..2 updated, 3..7 untouched
    learnGain = 16'h0000;
    for (int n = 0; n < DEPTH; n++) runCycle(150, 150, 1'b0, "R8 readback");
    // R7 wrap: index after DEPTH samples returns to 0
    runCycle(150, 150, 1'b0, "R7 wrap");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule